// File: doc/BRIEF.md
# Clock-Loss Soft Mute with Sample-Counted Ramp

This block sits in the digital sample path of a stereo audio converter, ahead of interpolation. It scales a left and a right two's-complement sample by a shared gain. When the converter clock becomes invalid, or when the clock ratio changes, the gain starts to fall at once. It falls one step per sample until the output sits at digital zero, which is the mid-scale quiescent level. Once the clock is valid again and the gain has reached zero, a soft-start ramp raises the gain back to full scale.

The ramp is counted in sample strobes, not in clock cycles. Its length in time therefore follows the sample rate: 960 samples last 20 ms at 48 kHz and proportionally longer at lower rates. The gain is held as a ramp position plus a fixed-point remainder. After k rising steps from zero the gain is exactly floor(k*1023/960), so every ramp lands on 1023 with no drift. If a ramp reverses part-way, it retraces the same staircase from the current position.

Top module: `audio_soft_mute`

## Requirements
- R1: While reset is asserted and right after it is released, out_vld is 0, out_l and out_r are 0, muted is 1, and the gain is 0.
- R2: The gain changes only in a cycle with sample_vld high, and by one ramp position per strobe. At ramp position k (0..960) the gain is floor(k*1023/960), so position 480 gives 511 and position 959 gives 1021.
- R3: In any cycle where clk_valid is low or ratio_chg is high, the ramp direction is down, and a strobe in that same cycle already steps the gain down.
- R4: An upward ramp starts only from gain 0, with clk_valid high and ratio_chg low. It takes exactly 960 strobes from 0 to reach 1023, and a down-ramp in progress keeps falling to 0 even when the clock turns valid again.
- R5: A mute event during an up-ramp reverses it from the current position, with no jump. Each following strobe lowers the position by one.
- R6: On a strobe, out_l and out_r are registered one cycle later as (input*gain)/1024, taken as signed and truncated toward zero, and out_vld is high for that one cycle. Between strobes the outputs hold their values.
- R7: A strobe taken while the gain is 0 produces outputs of exactly 0, whatever the input.
- R8: muted is 1 whenever the gain is below 1023 and 0 at 1023.
- R9: The gain saturates. Strobes at 1023 during an up-ramp keep it at 1023, and strobes at 0 while the clock is invalid keep it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_valid | input | 1 | High while the converter clock ratio is valid |
| ratio_chg | input | 1 | One-cycle pulse when the clock ratio changes |
| sample_vld | input | 1 | Sample strobe, one cycle per stereo sample |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_vld | output | 1 | Scaled sample valid, one cycle after sample_vld |
| out_l | output | 24 | Gain-scaled left sample |
| out_r | output | 24 | Gain-scaled right sample |
| muted | output | 1 | High while the gain is below full scale |

## Verification
A wrong ramp position or remainder appears as a wrong scaled value on the very next strobe, because the gain is applied to every sample. Feeding 1024 on the left channel makes out_l read back the gain directly. A direction register stuck in the wrong state appears as a gain that rises while the clock is invalid, or that keeps falling after zero. Either is visible within one strobe of the event. A remainder that drifts shows up only at the ramp ends, as a final value other than 1023, or as muted changing on a strobe other than the 960th.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl
  import soft_mute_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mute_evt,
  input  logic      at_zero,
  output ramp_dir_e dir_o
);
  ramp_dir_e dir_q, dir_nxt;

  // A mute event wins. Otherwise a finished down-ramp turns upward.
  always_comb begin
    dir_nxt = dir_q;
    if (mute_evt)
      dir_nxt = DIR_DOWN;
    else if (dir_q == DIR_DOWN && at_zero)
      dir_nxt = DIR_UP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= DIR_DOWN;
    else        dir_q <= dir_nxt;
  end

  assign dir_o = dir_nxt;

  // R4: a down-ramp that has not reached zero keeps going down
  assert_down_until_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_DOWN && !at_zero) |=> (dir_q == DIR_DOWN));
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import soft_mute_pkg::*;
#(
  parameter int GAIN_W   = 10,
  parameter int RAMP_LEN = 960
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  ramp_dir_e         dir_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              at_zero_o,
  output logic              at_full_o
);
  localparam int unsigned GMAX  = (1 << GAIN_W) - 1;
  localparam int unsigned QSTEP = GMAX / RAMP_LEN;
  localparam int unsigned RSTEP = GMAX % RAMP_LEN;
  localparam int POS_W = $clog2(RAMP_LEN + 1);
  localparam int REM_W = $clog2(RAMP_LEN);

  logic [POS_W-1:0]  pos_q, pos_nxt;
  logic [GAIN_W-1:0] gain_q, gain_nxt;
  logic [REM_W-1:0]  rem_q, rem_nxt;
  logic [REM_W:0]    rem_up, rem_up_wrap, rem_dn;
  logic              carry, borrow;

  assign at_zero_o = (pos_q == '0);
  assign at_full_o = (pos_q == POS_W'(RAMP_LEN));
  assign gain_o    = gain_q;

  // Remainder bookkeeping: gain = floor(pos*GMAX/RAMP_LEN), rem = pos*GMAX mod RAMP_LEN
  always_comb begin
    rem_up      = {1'b0, rem_q} + (REM_W+1)'(RSTEP);
    carry       = (rem_up >= (REM_W+1)'(RAMP_LEN));
    rem_up_wrap = carry ? (rem_up - (REM_W+1)'(RAMP_LEN)) : rem_up;
    borrow      = (rem_q < REM_W'(RSTEP));
    rem_dn      = {1'b0, rem_q} + (borrow ? (REM_W+1)'(RAMP_LEN) : '0) - (REM_W+1)'(RSTEP);
  end

  always_comb begin
    pos_nxt  = pos_q;
    gain_nxt = gain_q;
    rem_nxt  = rem_q;
    if (step_en) begin
      if (dir_i == DIR_UP && !at_full_o) begin
        pos_nxt  = pos_q + 1'b1;
        gain_nxt = gain_q + GAIN_W'(QSTEP) + GAIN_W'(carry);
        rem_nxt  = rem_up_wrap[REM_W-1:0];
      end else if (dir_i == DIR_DOWN && !at_zero_o) begin
        pos_nxt  = pos_q - 1'b1;
        gain_nxt = gain_q - GAIN_W'(QSTEP) - GAIN_W'(borrow);
        rem_nxt  = rem_dn[REM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      gain_q <= '0;
      rem_q  <= '0;
    end else if (step_en) begin
      pos_q  <= pos_nxt;
      gain_q <= gain_nxt;
      rem_q  <= rem_nxt;
    end
  end

  assert_ends_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full_o |-> (gain_q == GAIN_W'(GMAX))) and (at_zero_o |-> (gain_q == '0)));
  assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(gain_q));
  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ((int'(gain_q) - int'($past(gain_q)) <= int'(QSTEP) + 1) &&
                 (int'($past(gain_q)) - int'(gain_q) <= int'(QSTEP) + 1)));
endmodule

// File: rtl/soft_mute_scale.sv
module soft_mute_scale #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic        [GAIN_W-1:0]   gain,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] dout
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;

  logic signed [PW-1:0]       prod, biased, shifted;
  logic signed [SAMPLE_W-1:0] dout_q, dout_nxt;

  // Add (2^GAIN_W - 1) to negative products so the shift truncates toward zero
  always_comb begin
    prod     = $signed(din) * $signed({1'b0, gain});
    biased   = prod + (prod[PW-1] ? PW'((1 << GAIN_W) - 1) : PW'(0));
    shifted  = biased >>> GAIN_W;
    dout_nxt = shifted[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout_q <= '0;
    else if (en) dout_q <= dout_nxt;
  end

  assign dout = dout_q;

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((&shifted[PW-1:SAMPLE_W-1]) || !(|shifted[PW-1:SAMPLE_W-1])));
endmodule

// File: rtl/audio_soft_mute.sv
module audio_soft_mute
  import soft_mute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 10,
  parameter int RAMP_LEN = 960
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clk_valid,
  input  logic                       ratio_chg,
  input  logic                       sample_vld,
  input  logic signed [SAMPLE_W-1:0] in_l,
  input  logic signed [SAMPLE_W-1:0] in_r,
  output logic                       out_vld,
  output logic signed [SAMPLE_W-1:0] out_l,
  output logic signed [SAMPLE_W-1:0] out_r,
  output logic                       muted
);
  localparam int NCH = 2;

  logic              mute_evt, at_zero, at_full, vld_q;
  ramp_dir_e         dir;
  logic [GAIN_W-1:0] gain;
  logic signed [SAMPLE_W-1:0] din_a  [NCH];
  logic signed [SAMPLE_W-1:0] dout_a [NCH];

  assign mute_evt = !clk_valid || ratio_chg;

  soft_mute_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mute_evt (mute_evt),
    .at_zero  (at_zero),
    .dir_o    (dir)
  );

  soft_mute_ramp #(.GAIN_W(GAIN_W), .RAMP_LEN(RAMP_LEN)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (sample_vld),
    .dir_i     (dir),
    .gain_o    (gain),
    .at_zero_o (at_zero),
    .at_full_o (at_full)
  );

  always_comb begin
    din_a[0] = in_l;
    din_a[1] = in_r;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    soft_mute_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sample_vld),
      .gain  (gain),
      .din   (din_a[ch]),
      .dout  (dout_a[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= sample_vld;
  end

  assign out_vld = vld_q;
  assign out_l   = dout_a[0];
  assign out_r   = dout_a[1];
  assign muted   = !at_full;

  assert_mute_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_evt && sample_vld && !at_zero) |=> (gain < $past(gain)));
  assert_rise_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain > $past(gain)) |-> ($past(clk_valid) && !$past(ratio_chg)));
  assert_zero_at_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && gain == '0) |=> (out_l == '0 && out_r == '0));
  assert_muted_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (muted == 1'b0) |-> (gain == '1));
endmodule

// File: tb/audio_soft_mute_tb_top.sv
`timescale 1ns/1ps
module audio_soft_mute_tb_top;
  logic clk = 1'b0;
  logic rst_n, clk_valid, ratio_chg, sample_vld;
  logic signed [23:0] in_l, in_r, out_l, out_r;
  logic out_vld, muted;
  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  audio_soft_mute dut_i (
    .clk(clk), .rst_n(rst_n), .clk_valid(clk_valid), .ratio_chg(ratio_chg),
    .sample_vld(sample_vld), .in_l(in_l), .in_r(in_r),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r), .muted(muted)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: ramp position, direction, expected outputs
  int     m_k = 0;
  bit     m_up = 1'b0;
  longint e_l = 0, e_r = 0;
  bit     e_v = 1'b0, e_m = 1'b1;

  function automatic int gain_of(input int k);
    return (k * 1023) / 960;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 0; m_up = 1'b0; e_l = 0; e_r = 0; e_v = 1'b0; e_m = 1'b1;
    end else begin
      int g;
      g = gain_of(m_k);
      e_v = sample_vld;
      if (sample_vld) begin
        e_l = (longint'(in_l) * g) / 1024;
        e_r = (longint'(in_r) * g) / 1024;
      end
      if (!clk_valid || ratio_chg) m_up = 1'b0;
      else if (!m_up && m_k == 0) m_up = 1'b1;
      if (sample_vld) begin
        if (m_up && m_k < 960) m_k++;
        else if (!m_up && m_k > 0) m_k--;
      end
      e_m = (gain_of(m_k) != 1023);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(out_vld == e_v, "R6 out_vld", longint'(out_vld), longint'(e_v));
      chk(longint'(out_l) == e_l, "R6 out_l", longint'(out_l), e_l);
      chk(longint'(out_r) == e_r, "R6 out_r", longint'(out_r), e_r);
      chk(muted == e_m, "R8 muted", longint'(muted), longint'(e_m));
    end
  end

  // One strobe: drive at a falling edge, capture at the next, one idle cycle after
  task automatic strobe(input logic signed [23:0] l, input logic signed [23:0] r,
                        output logic signed [23:0] ol);
    sample_vld = 1'b1; in_l = l; in_r = r;
    @(negedge clk);
    ol = out_l;
    sample_vld = 1'b0;
    ratio_chg = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    logic signed [23:0] ol;
    rst_n = 1'b0; clk_valid = 1'b0; ratio_chg = 1'b0; sample_vld = 1'b0;
    in_l = '0; in_r = '0;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0 && out_l == 0 && out_r == 0, "R1 outputs in reset", longint'(out_l), 0);
    chk(muted == 1'b1, "R1 muted in reset", longint'(muted), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0 && muted == 1'b1, "R1 after release", longint'(muted), 1);
    cmp_on = 1'b1;

    // Invalid clock: gain stays at zero, outputs exactly zero
    for (int i = 0; i < 4; i++) begin
      strobe(24'sd1024, -24'sd5000, ol);
      chk(ol == 0 && out_r == 0, "R7 zero output while muted", longint'(out_r), 0);
    end
    chk(muted == 1'b1, "R9 gain held at zero", longint'(muted), 1);

    // Up-ramp to position 480
    clk_valid = 1'b1;
    for (int i = 0; i < 480; i++) strobe(24'sd1024, 24'sd777, ol);
    strobe(24'sd1024, -24'sd3, ol);
    chk(ol == 511, "R2 gain at position 480", longint'(ol), 511);

    // Reversal mid-ramp
    clk_valid = 1'b0;
    strobe(24'sd1024, 24'sd100, ol);
    chk(ol == 512, "R5 reversal starts at current gain", longint'(ol), 512);
    strobe(24'sd1024, 24'sd100, ol);
    chk(ol == 511, "R5 one position down", longint'(ol), 511);

    // No strobe, no change
    repeat (10) @(negedge clk);
    chk(out_l == 511, "R2 held between strobes", longint'(out_l), 511);
    strobe(24'sd1024, 24'sd100, ol);
    chk(ol == 510, "R2 next strobe steps once", longint'(ol), 510);

    // Valid again: down-ramp must still finish before rising
    clk_valid = 1'b1;
    strobe(24'sd1024, 24'sd100, ol);
    chk(ol == 509, "R4 down-ramp continues after valid", longint'(ol), 509);
    for (int i = 0; i < 477; i++) strobe(24'sd1024, -24'sd4096, ol);
    for (int i = 0; i < 959; i++) strobe(24'sd1024, 24'sd4095, ol);
    chk(muted == 1'b1, "R4 still muted after 959 strobes", longint'(muted), 1);
    strobe(24'sd1024, 24'sd4095, ol);
    chk(muted == 1'b0, "R4 full scale after 960 strobes", longint'(muted), 0);
    strobe(24'sd1024, 24'sd0, ol);
    chk(ol == 1023, "R9 gain at full", longint'(ol), 1023);
    strobe(24'sd1024, 24'sd0, ol);
    chk(ol == 1023 && muted == 1'b0, "R9 saturated at full", longint'(ol), 1023);

    // Extreme values at full gain
    strobe(-24'sd8388608, 24'sd8388607, ol);
    chk(ol == -8380416, "R6 most negative input", longint'(ol), -8380416);

    // Ratio change pulse
    ratio_chg = 1'b1;
    strobe(24'sd1024, 24'sd1, ol);
    chk(ol == 1023, "R3 event strobe uses current gain", longint'(ol), 1023);
    strobe(24'sd1024, 24'sd1, ol);
    chk(ol == 1021 && muted == 1'b1, "R3 immediate step down", longint'(ol), 1021);

    // Mixed traffic with clock-valid toggles and ratio pulses
    for (int i = 0; i < 2500; i++) begin
      if (i % 700 == 350) clk_valid = 1'b0;
      if (i % 700 == 420) clk_valid = 1'b1;
      if (i % 900 == 600) ratio_chg = 1'b1;
      strobe(24'(i * 3371 - 4000000), 24'(-(i * 1999) + 123), ol);
      if (i % 5 == 0) @(negedge clk);
    end

    cmp_on = 1'b0;
    finish_run();
  end
endmodule